// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 64 interrupt sources and presents them to a processor through a small register bus. It also drives two request lines, a fast one and a normal one. Each source input is watched for a rising edge. An edge latches a pending flag, and that flag stays set until software clears it by writing a one to its bit. Software sets a per-source enable bit and a 3-bit priority. A priority of 0 or 1 sends the source to the fast line, and a priority of 2 to 7 sends it to the normal line.

The block saves the handler a search step. It keeps a read-only vector word that always names the most urgent pending source. The value is a programmable base plus (source index + 1) × 4. The handler reads that word, recovers the source number from it, and clears the matching pending bit. A control bit lets the vector word also consider sources that are pending but not enabled. The two request lines always obey the enables.

Top module: `icp_vec_intc`

## Requirements
- R1: After reset every pending, enable, priority, base and control register reads 0, `fiq_o` and `irq_o` are low, and the vector word at 0x14 reads 0.
- R2: The pending flag of source n is set by the clock edge that first samples `src_i[n]` high after it was sampled low. Holding the input high sets nothing more, so a flag cleared while the input stays high remains clear.
- R3: Writing a word to 0x00/0x04 or to 0x08/0x0C clears the pending flag of every source whose bit is 1 in that word. Bit b of the word at offset +4w stands for source 32w+b. Bits written as 0 change nothing.
- R4: If a rising edge and a clearing write hit the same source in the same cycle, the pending flag ends up set.
- R5: The words at 0x00/0x04 read the pending flags of sources with priority 0 or 1. The words at 0x08/0x0C read the pending flags of sources with priority 2 to 7. Both views use the bit layout of R3.
- R6: The enable words at 0x18/0x1C are read/write, with the bit layout of R3. A 1 enables a source.
- R7: The priority word at 0x30+4r holds source 8r+k in bits [4k+2:4k]. Bit 4k+3 is ignored on write and reads 0.
- R8: The vector word at 0x14 reads base + (i+1)×4, where i is the candidate source with the smallest priority value. When two candidates share that value, the lower index wins.
- R9: With no candidate, the vector word reads the base value unchanged.
- R10: Control word 0x20 keeps only bit 0. When bit 0 is 0, the candidates are the pending enabled sources. When bit 0 is 1, the candidates are all pending sources.
- R11: The base word at 0x24 is a full 32-bit read/write register.
- R12: `fiq_o` and `irq_o` are registered. One cycle after the state changes, `fiq_o` is high when some pending enabled source has priority 0–1, and `irq_o` is high when some pending enabled source has priority 2–7. The control bit does not affect them.
- R13: `rdata_o` loads the addressed value on the clock edge that samples `rd_en_i` high and holds its value otherwise. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt source inputs |
| addr_i | input | 8 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two functions can act on the same pending flag in one cycle: a new rising edge on a source, and a software write that clears it. The bench raises a source input and writes a one to that source's pending bit in the same cycle, in both pending views. It then reads the flag back through the pending words and expects it to be set. A clear issued on a later cycle, while the input is still held high, must leave the flag cleared. Random runs mix edges, clears and configuration writes, and every read is checked against a bench model.

// File: rtl/icp_pkg.sv
`timescale 1ns/1ps
package icp_pkg;
   localparam int ADDR_W   = 8;
   localparam int DATA_W   = 32;
   localparam int A_FIQ    = 'h00;
   localparam int A_IRQ    = 'h08;
   localparam int A_ENTRY  = 'h14;
   localparam int A_EN     = 'h18;
   localparam int A_CTRL   = 'h20;
   localparam int A_BASE   = 'h24;
   localparam int A_PRIO   = 'h30;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_FIQ, SEL_IRQ, SEL_ENTRY, SEL_EN, SEL_CTRL, SEL_BASE, SEL_PRIO
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e   sel;
      logic [2:0] idx;
   } reg_dec_t;

   function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                            input int nw, input int np);
      reg_dec_t d;
      int ai;
      ai    = int'(a);
      d.sel = SEL_NONE;
      d.idx = '0;
      if (a[1:0] == 2'b00) begin
         if (ai >= A_FIQ && ai < A_FIQ + 4*nw) begin
            d.sel = SEL_FIQ;  d.idx = 3'((ai - A_FIQ) >> 2);
         end else if (ai >= A_IRQ && ai < A_IRQ + 4*nw) begin
            d.sel = SEL_IRQ;  d.idx = 3'((ai - A_IRQ) >> 2);
         end else if (ai == A_ENTRY) begin
            d.sel = SEL_ENTRY;
         end else if (ai >= A_EN && ai < A_EN + 4*nw) begin
            d.sel = SEL_EN;   d.idx = 3'((ai - A_EN) >> 2);
         end else if (ai == A_CTRL) begin
            d.sel = SEL_CTRL;
         end else if (ai == A_BASE) begin
            d.sel = SEL_BASE;
         end else if (ai >= A_PRIO && ai < A_PRIO + 4*np) begin
            d.sel = SEL_PRIO; d.idx = 3'((ai - A_PRIO) >> 2);
         end
      end
      return d;
   endfunction
endpackage

// File: rtl/icp_edge_latch.sv
`timescale 1ns/1ps
module icp_edge_latch #(
   parameter int N = 64
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] src_q;
   logic [N-1:0] pend_q;
   logic [N-1:0] rise;

   assign rise   = src_i & ~src_q;
   assign pend_o = pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q  <= '0;
         pend_q <= '0;
      end else begin
         src_q  <= src_i;
         pend_q <= (pend_q & ~clr_i) | rise;
      end
   end

   // R3: a clear without a concurrent edge leaves the flag low
   a_r3_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ((pend_q & $past(clr_i & ~rise)) == '0));
   // R4: an edge always leaves the flag set, even against a clear
   a_r4_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ((~pend_q & $past(rise)) == '0));
   // R2: a flag never appears without an edge
   a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ((pend_q & ~$past(pend_q) & ~$past(rise)) == '0));
endmodule

// File: rtl/icp_prio_pick.sv
`timescale 1ns/1ps
module icp_prio_pick #(
   parameter int N  = 64,
   parameter int PW = 3,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]         cand_i,
   input  logic [N-1:0][PW-1:0] prio_i,
   output logic                 vld_o,
   output logic [IW-1:0]        idx_o
);
   logic [PW-1:0] best;

   always_comb begin
      vld_o = 1'b0;
      idx_o = '0;
      best  = '1;
      for (int i = 0; i < N; i++) begin
         if (cand_i[i] && (!vld_o || prio_i[i] < best)) begin
            vld_o = 1'b1;
            idx_o = IW'(i);
            best  = prio_i[i];
         end
      end
   end

   always_comb begin
      if (vld_o) begin
         a_r8_win_is_cand: assert (cand_i[idx_o]);
         for (int i = 0; i < N; i++) begin
            // R8: nobody beats the winner, ties go to the lower index
            a_r8_no_better: assert (!(cand_i[i] &&
               (prio_i[i] < prio_i[idx_o] || (prio_i[i] == prio_i[idx_o] && IW'(i) < idx_o))));
         end
      end else begin
         a_r9_none: assert (cand_i == '0);
      end
   end
endmodule

// File: rtl/icp_vec_intc.sv
`timescale 1ns/1ps
module icp_vec_intc
   import icp_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int PRIO_W     = 3,
   parameter int FIQ_LEVELS = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NUM_SRC-1:0]  src_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic                wr_en_i,
   input  logic                rd_en_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic                irq_o,
   output logic                fiq_o
);
   localparam int NW = NUM_SRC / 32;
   localparam int NP = NUM_SRC / 8;
   localparam int IW = $clog2(NUM_SRC);

   if (NUM_SRC % 32 != 0 || NUM_SRC < 32 || NUM_SRC > 64) begin : g_bad_src
      $error("NUM_SRC must be 32 or 64");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_pw
      $error("PRIO_W must be 1..4");
   end
   if (FIQ_LEVELS < 0 || FIQ_LEVELS > (1 << PRIO_W)) begin : g_bad_fl
      $error("FIQ_LEVELS out of range");
   end

   reg_dec_t                      dec;
   logic [NUM_SRC-1:0]            en_q, pend, clr, is_fiq, cand;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [DATA_W-1:0]             base_q, entry_val, rd_val, rdata_q;
   logic                          ctrl_q, win_vld, fiq_q, irq_q;
   logic [IW-1:0]                 win_idx;

   assign dec = decode_addr(addr_i, NW, NP);

   always_comb begin
      clr = '0;
      for (int w = 0; w < NW; w++) begin
         if (wr_en_i && (dec.sel == SEL_FIQ || dec.sel == SEL_IRQ) && dec.idx == 3'(w))
            clr[32*w +: 32] = wdata_i;
      end
   end

   icp_edge_latch #(.N(NUM_SRC)) u_latch (
      .clk_i (clk_i), .rst_ni (rst_ni), .src_i (src_i), .clr_i (clr), .pend_o (pend)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '0;
         prio_q <= '0;
         base_q <= '0;
         ctrl_q <= 1'b0;
      end else if (wr_en_i) begin
         case (dec.sel)
            SEL_EN: begin
               for (int w = 0; w < NW; w++)
                  if (dec.idx == 3'(w)) en_q[32*w +: 32] <= wdata_i;
            end
            SEL_PRIO: begin
               for (int r = 0; r < NP; r++)
                  if (dec.idx == 3'(r))
                     for (int k = 0; k < 8; k++)
                        prio_q[8*r+k] <= wdata_i[4*k +: PRIO_W];
            end
            SEL_CTRL: ctrl_q <= wdata_i[0];
            SEL_BASE: base_q <= wdata_i;
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
      assign is_fiq[i] = (int'(prio_q[i]) < FIQ_LEVELS);
   end

   assign cand = pend & (en_q | {NUM_SRC{ctrl_q}});

   icp_prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick (
      .cand_i (cand), .prio_i (prio_q), .vld_o (win_vld), .idx_o (win_idx)
   );

   assign entry_val = base_q + (win_vld ? ((32'(win_idx) + 32'd1) << 2) : 32'd0);

   always_comb begin
      rd_val = '0;
      case (dec.sel)
         SEL_FIQ, SEL_IRQ: begin
            for (int w = 0; w < NW; w++)
               if (dec.idx == 3'(w))
                  rd_val = pend[32*w +: 32] &
                           ((dec.sel == SEL_FIQ) ? is_fiq[32*w +: 32] : ~is_fiq[32*w +: 32]);
         end
         SEL_ENTRY: rd_val = entry_val;
         SEL_EN: begin
            for (int w = 0; w < NW; w++)
               if (dec.idx == 3'(w)) rd_val = en_q[32*w +: 32];
         end
         SEL_CTRL: rd_val = {31'b0, ctrl_q};
         SEL_BASE: rd_val = base_q;
         SEL_PRIO: begin
            for (int r = 0; r < NP; r++)
               if (dec.idx == 3'(r))
                  for (int k = 0; k < 8; k++)
                     rd_val[4*k +: PRIO_W] = prio_q[8*r+k];
         end
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_q <= '0;
         fiq_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (rd_en_i) rdata_q <= rd_val;
         fiq_q <= |(pend & en_q & is_fiq);
         irq_q <= |(pend & en_q & ~is_fiq);
      end
   end

   assign rdata_o = rdata_q;
   assign fiq_o   = fiq_q;
   assign irq_o   = irq_q;

   // R12: a request line only rises after an enabled flag was pending
   a_r12_fiq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(fiq_o) |-> $past(|(pend & en_q)));
   a_r12_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(|(pend & en_q)));
   // R9: an empty vector read returns the base
   a_r9_empty_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && dec.sel == SEL_ENTRY && !win_vld) |=> (rdata_o == $past(base_q)));
   // R13: read data holds without a read strobe
   a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/icp_vec_intc_tb_top.sv
`timescale 1ns/1ps
module icp_vec_intc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [31:0] rdata;
   logic        irq, fiq;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   logic [63:0] m_pend = '0, m_en = '0, m_src = '0;
   logic [2:0]  m_pr [64];
   logic [31:0] m_base = '0;
   logic        m_ctrl = 1'b0;

   always #4 clk = ~clk;

   icp_vec_intc dut_i (
      .clk_i (clk), .rst_ni (rst_n), .src_i (src), .addr_i (addr), .wdata_i (wdata),
      .wr_en_i (we), .rd_en_i (re), .rdata_o (rdata), .irq_o (irq), .fiq_o (fiq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] fiq_mask();
      logic [63:0] m;
      for (int i = 0; i < 64; i++) m[i] = (m_pr[i] < 3'd2);
      return m;
   endfunction

   function automatic logic [31:0] f_entry();
      logic [63:0] c;
      int best_i;
      c = m_pend & (m_en | {64{m_ctrl}});
      best_i = -1;
      for (int i = 0; i < 64; i++)
         if (c[i] && (best_i < 0 || m_pr[i] < m_pr[best_i])) best_i = i;
      if (best_i < 0) return m_base;
      return m_base + 32'((best_i + 1) * 4);
   endfunction

   function automatic logic [31:0] f_read(input logic [7:0] a);
      logic [31:0] v;
      v = '0;
      case (a)
         8'h00: v = m_pend[31:0]  & fiq_mask()[31:0];
         8'h04: v = m_pend[63:32] & fiq_mask()[63:32];
         8'h08: v = m_pend[31:0]  & ~fiq_mask()[31:0];
         8'h0C: v = m_pend[63:32] & ~fiq_mask()[63:32];
         8'h14: v = f_entry();
         8'h18: v = m_en[31:0];
         8'h1C: v = m_en[63:32];
         8'h20: v = {31'b0, m_ctrl};
         8'h24: v = m_base;
         default: begin
            if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
               for (int k = 0; k < 8; k++)
                  v[4*k +: 3] = m_pr[(int'(a) - 'h30) / 4 * 8 + k];
         end
      endcase
      return v;
   endfunction

   // one clock cycle; model follows the clock edge
   task automatic step(input logic [63:0] s, input bit w, input bit r,
                       input logic [7:0] a, input logic [31:0] d, output logic [31:0] exp_rd);
      logic [63:0] rise, clr;
      @(negedge clk);
      src = s; we = w; re = r; addr = a; wdata = d;
      exp_rd = f_read(a);
      @(posedge clk);
      rise = s & ~m_src;
      clr  = '0;
      if (w) begin
         case (a)
            8'h00, 8'h08: clr[31:0]  = d;
            8'h04, 8'h0C: clr[63:32] = d;
            8'h18: m_en[31:0]  = d;
            8'h1C: m_en[63:32] = d;
            8'h20: m_ctrl = d[0];
            8'h24: m_base = d;
            default: begin
               if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
                  for (int k = 0; k < 8; k++)
                     m_pr[(int'(a) - 'h30) / 4 * 8 + k] = d[4*k +: 3];
            end
         endcase
      end
      m_pend = (m_pend & ~clr) | rise;
      m_src  = s;
      #2;
      we = 1'b0; re = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] x;
      step(m_src, 1'b1, 1'b0, a, d, x);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a);
      logic [31:0] e;
      step(m_src, 1'b0, 1'b1, a, 32'h0, e);
      chk(req, rdata, e);
   endtask

   task automatic pulse(input logic [63:0] m);
      logic [31:0] x;
      step(m, 1'b0, 1'b0, 8'h00, 32'h0, x);
      step(64'h0, 1'b0, 1'b0, 8'h00, 32'h0, x);
   endtask

   task automatic lines_chk(input string req);
      logic [31:0] x;
      step(m_src, 1'b0, 1'b0, 8'h00, 32'h0, x);
      chk({req, " fiq"}, {31'b0, fiq}, {31'b0, |(m_pend & m_en & fiq_mask())});
      chk({req, " irq"}, {31'b0, irq}, {31'b0, |(m_pend & m_en & ~fiq_mask())});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] x;
      logic [7:0] alist [16];
      void'($urandom(32'd7341));
      for (int i = 0; i < 64; i++) m_pr[i] = 3'd0;
      alist = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h18, 8'h1C, 8'h20,
                8'h24, 8'h30, 8'h38, 8'h4C, 8'h10, 8'h28, 8'h2C, 8'h14};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 fiq", {31'b0, fiq}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rd_chk("R1 entry", 8'h14);
      rd_chk("R1 enable", 8'h1C);
      rd_chk("R1 prio", 8'h44);

      // R13 unmapped and hold
      rd_chk("R13 unmapped", 8'h2C);
      step(m_src, 1'b0, 1'b0, 8'h24, 32'h0, x);
      chk("R13 hold", rdata, 32'h0);

      // R7 priority field packing, bit 3 ignored
      wr(8'h30, 32'hFFFF_FFFF);
      rd_chk("R7 pack", 8'h30);
      chk("R7 bit3 zero", rdata, 32'h7777_7777);
      wr(8'h30, 32'h0000_0000);
      wr(8'h34, 32'h0000_0030);   // source 9 -> prio 3
      wr(8'h3C, 32'h0000_0200);   // source 26 -> prio 2

      // R2/R12 edge latch and routing latency
      wr(8'h18, 32'h0000_0200);
      step(64'h200, 1'b0, 1'b0, 8'h00, 32'h0, x);
      chk("R12 latency", {31'b0, irq}, 32'h0);
      step(64'h200, 1'b0, 1'b0, 8'h00, 32'h0, x);
      chk("R12 irq up", {31'b0, irq}, 32'h1);
      chk("R12 fiq low", {31'b0, fiq}, 32'h0);
      rd_chk("R5 irq view", 8'h08);
      chk("R5 irq view bit9", rdata, 32'h0000_0200);
      rd_chk("R8 entry idx9", 8'h14);
      chk("R8 entry value", rdata, 32'd40);
      // R2: clear while held high stays clear
      wr(8'h08, 32'h0000_0200);
      step(64'h200, 1'b0, 1'b0, 8'h00, 32'h0, x);
      rd_chk("R2 held high no reset", 8'h08);
      chk("R2 held high value", rdata, 32'h0);
      step(64'h0, 1'b0, 1'b0, 8'h00, 32'h0, x);

      // R4 edge and clear in same cycle, in both views
      step(64'h4, 1'b1, 1'b0, 8'h00, 32'h4, x);
      rd_chk("R4 set wins fiq view", 8'h00);
      chk("R4 bit2 set", rdata, 32'h4);
      step(64'h0, 1'b0, 1'b0, 8'h00, 32'h0, x);
      step(64'h200, 1'b1, 1'b0, 8'h08, 32'h200, x);
      rd_chk("R4 set wins irq view", 8'h08);
      step(64'h0, 1'b0, 1'b0, 8'h00, 32'h0, x);

      // R3 clear via other view, zero bits ignored
      wr(8'h08, 32'h0000_0000);
      rd_chk("R3 zero write keeps", 8'h00);
      wr(8'h08, 32'h0000_0004);
      rd_chk("R3 cleared", 8'h00);
      chk("R3 cleared value", rdata, 32'h0);

      // R8 tie broken to lower index; R9 base only; R10 ctrl; R11 base
      wr(8'h18, 32'h0);
      pulse(64'h0400_0200);       // sources 9 and 26, prio 3 and 2
      rd_chk("R9 disabled gives base", 8'h14);
      chk("R9 value", rdata, 32'h0);
      wr(8'h20, 32'hFFFF_FFFF);
      rd_chk("R10 ctrl readback", 8'h20);
      rd_chk("R10 all pending", 8'h14);
      chk("R10 idx26 wins", rdata, 32'd108);
      wr(8'h3C, 32'h0000_0300);   // source 26 -> prio 3, tie with 9
      wr(8'h24, 32'h8000_1000);
      rd_chk("R11 base", 8'h24);
      rd_chk("R8 tie lower index", 8'h14);
      chk("R8 tie value", rdata, 32'h8000_1028);
      lines_chk("R12 ctrl no effect");
      wr(8'h20, 32'h0);
      wr(8'h1C, 32'h8000_0000);
      pulse(64'h8000_0000_0000_0000);
      lines_chk("R12 fiq src63");
      rd_chk("R6 enable hi", 8'h1C);
      rd_chk("R5 fiq view hi", 8'h04);
      rd_chk("R8 entry src63", 8'h14);

      // random mix
      for (int it = 0; it < 1500; it++) begin
         int op;
         op = int'($urandom % 8);
         case (op)
            0: pulse({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            1: wr(($urandom % 2) ? 8'h1C : 8'h18, $urandom);
            2: wr(8'h30 + 8'(4 * ($urandom % 8)), $urandom);
            3: wr(8'(4 * ($urandom % 4)), $urandom & $urandom);
            4: rd_chk("R8 R5 R6 R7 random read", alist[$urandom % 16]);
            5: lines_chk("R12 random");
            6: wr(8'h20, $urandom);
            default: wr(8'h24, $urandom);
         endcase
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule